// File: doc/BRIEF.md
# Multiplexed address/data port pair

This block holds the two 8-bit general-purpose ports of a small microcontroller core. The same pins also serve as its external memory bus. The low port carries the low address byte and then data on the same pins, one after the other. The high port carries the upper address byte. Each port has an output latch that the internal bus can write, and two read paths back to the internal bus: one returns the latch contents and one returns the pin levels. Each pin has a drive-enable output and a drive-value output for the pad.

While the port is plain I/O, the low port behaves as open drain. A latch bit of 0 pulls the pin low. A latch bit of 1 releases the pin, since there is no internal pull-up. The high port drives its latch value through a pull-up network, so a latch bit of 1 holds the pin high. A bus cycle is requested on a two-bit phase input, which takes the values address, data-out and data-in. During a bus cycle:
- The low port drives both levels actively, except in data-in, where it floats so that the external device can drive the pins. The read data then comes from the low port's pin-read path.
- Every bus cycle forces the low latch to all ones.
- The high latch is kept unchanged, and its value returns to the pins when the bus is released.

Top module: `adp_port_pair`

## Requirements
- R1: While rst_ni is low, both latches read 0xFF and both pin-read paths read 0x00.
- R2: With bus_phase_i = 2'b00 (idle), a write strobe loads wdata_i into the selected latch on the rising edge. The new value appears on that port's latch-read output after the edge.
- R3: In idle, lo_oe_o equals the bitwise inverse of the low latch and lo_do_o is 0x00. A latch 0 bit drives the pin low and a latch 1 bit floats.
- R4: In idle, hi_oe_o is 0xFF and hi_do_o equals the high latch.
- R5: In the address phase (bus_phase_i = 2'b01), lo_oe_o is 0xFF and lo_do_o equals bus_addr_i[7:0].
- R6: In the data-out phase (bus_phase_i = 2'b10), lo_oe_o is 0xFF and lo_do_o equals bus_wdata_i.
- R7: In the data-in phase (bus_phase_i = 2'b11), lo_oe_o is 0x00 and lo_do_o is 0x00.
- R8: Any rising edge with bus_phase_i not idle sets the low latch to 0xFF. This takes priority over a write to the low latch in the same cycle.
- R9: With bus_phase_i not idle, hi_oe_o is 0xFF and hi_do_o equals bus_addr_i[15:8].
- R10: The high latch keeps its value through bus cycles, and writes to it during a bus cycle are ignored. After the bus returns to idle, hi_do_o again shows the high latch.
- R11: lo_pin_rd_o and hi_pin_rd_o show the pin levels sampled at the previous rising edge. External read data is therefore available on lo_pin_rd_o one cycle after the data-in phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Write strobe for the low latch |
| wr_hi_i | input | 1 | Write strobe for the high latch |
| wdata_i | input | 8 | Write data from the internal bus |
| bus_phase_i | input | 2 | Bus phase: 00 idle, 01 address, 10 data-out, 11 data-in |
| bus_addr_i | input | 16 | External bus address |
| bus_wdata_i | input | 8 | External bus write data |
| lo_pin_i | input | 8 | Low port pad levels |
| hi_pin_i | input | 8 | High port pad levels |
| lo_oe_o | output | 8 | Low port per-pin drive enable |
| lo_do_o | output | 8 | Low port per-pin drive value |
| hi_oe_o | output | 8 | High port per-pin drive enable |
| hi_do_o | output | 8 | High port per-pin drive value |
| lo_latch_rd_o | output | 8 | Low latch read path |
| hi_latch_rd_o | output | 8 | High latch read path |
| lo_pin_rd_o | output | 8 | Low port pin read path |
| hi_pin_rd_o | output | 8 | High port pin read path |

## Verification
The drive outputs are combinational from the phase input and the latches. A corrupted latch therefore shows on lo_oe_o or hi_do_o within the same idle cycle, and on the latch-read outputs one edge after the corrupting event. A failed force, or a high latch disturbed by a bus cycle, shows at the first idle cycle after the bus cycle. Random phase sequences mixed with writes are applied, so bus cycles overlap writes, including writes that collide with a bus cycle in the same cycle.

// File: rtl/adp_pkg.sv
package adp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_ADDR = 2'b01,
    PH_DOUT = 2'b10,
    PH_DIN  = 2'b11
  } bus_phase_e;
endpackage

// File: rtl/adp_latch.sv
module adp_latch #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         force_i,
  input  logic         hold_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            q_o <= '1;
    else if (force_i)       q_o <= '1;   // bus force beats CPU write
    else if (wr_i && !hold_i) q_o <= wdata_i;
  end
endmodule

// File: rtl/adp_pin_sampler.sv
module adp_pin_sampler #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= pin_i;
  end
endmodule

// File: rtl/adp_lo_drive.sv
module adp_lo_drive
  import adp_pkg::*;
#(
  parameter int W = 8
) (
  input  bus_phase_e   phase_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] do_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_comb begin
      unique case (phase_i)
        PH_ADDR: begin oe_o[b] = 1'b1;        do_o[b] = addr_i[b];  end
        PH_DOUT: begin oe_o[b] = 1'b1;        do_o[b] = wdata_i[b]; end
        PH_DIN:  begin oe_o[b] = 1'b0;        do_o[b] = 1'b0;       end
        default: begin oe_o[b] = ~latch_i[b]; do_o[b] = 1'b0;       end // open drain
      endcase
    end
  end
endmodule

// File: rtl/adp_hi_drive.sv
module adp_hi_drive #(
  parameter int W = 8
) (
  input  logic         bus_act_i,
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] addr_i,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] do_o
);
  assign oe_o = '1;  // pull-up network: always driven
  assign do_o = bus_act_i ? addr_i : latch_i;
endmodule

// File: rtl/adp_port_pair.sv
module adp_port_pair
  import adp_pkg::*;
#(
  parameter int W  = 8,
  localparam int AW = 2 * W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_lo_i,
  input  logic          wr_hi_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [1:0]    bus_phase_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [W-1:0]  bus_wdata_i,
  input  logic [W-1:0]  lo_pin_i,
  input  logic [W-1:0]  hi_pin_i,
  output logic [W-1:0]  lo_oe_o,
  output logic [W-1:0]  lo_do_o,
  output logic [W-1:0]  hi_oe_o,
  output logic [W-1:0]  hi_do_o,
  output logic [W-1:0]  lo_latch_rd_o,
  output logic [W-1:0]  hi_latch_rd_o,
  output logic [W-1:0]  lo_pin_rd_o,
  output logic [W-1:0]  hi_pin_rd_o
);
  bus_phase_e phase;
  logic       bus_act;
  logic [W-1:0] lo_q, hi_q;

  assign phase   = bus_phase_e'(bus_phase_i);
  assign bus_act = (phase != PH_IDLE);

  adp_latch #(.W(W)) u_lo_latch (
    .clk_i, .rst_ni, .wr_i(wr_lo_i), .wdata_i,
    .force_i(bus_act), .hold_i(1'b0), .q_o(lo_q)
  );

  adp_latch #(.W(W)) u_hi_latch (
    .clk_i, .rst_ni, .wr_i(wr_hi_i), .wdata_i,
    .force_i(1'b0), .hold_i(bus_act), .q_o(hi_q)
  );

  adp_pin_sampler #(.W(W)) u_lo_pin (
    .clk_i, .rst_ni, .pin_i(lo_pin_i), .q_o(lo_pin_rd_o)
  );

  adp_pin_sampler #(.W(W)) u_hi_pin (
    .clk_i, .rst_ni, .pin_i(hi_pin_i), .q_o(hi_pin_rd_o)
  );

  adp_lo_drive #(.W(W)) u_lo_drv (
    .phase_i(phase), .latch_i(lo_q), .addr_i(bus_addr_i[W-1:0]),
    .wdata_i(bus_wdata_i), .oe_o(lo_oe_o), .do_o(lo_do_o)
  );

  adp_hi_drive #(.W(W)) u_hi_drv (
    .bus_act_i(bus_act), .latch_i(hi_q), .addr_i(bus_addr_i[AW-1:W]),
    .oe_o(hi_oe_o), .do_o(hi_do_o)
  );

  assign lo_latch_rd_o = lo_q;
  assign hi_latch_rd_o = hi_q;
endmodule

// File: rtl/adp_port_pair_chk.sv
module adp_port_pair_chk #(
  parameter int W  = 8,
  localparam int AW = 2 * W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_lo_i,
  input logic          wr_hi_i,
  input logic [W-1:0]  wdata_i,
  input logic [1:0]    bus_phase_i,
  input logic [AW-1:0] bus_addr_i,
  input logic [W-1:0]  bus_wdata_i,
  input logic [W-1:0]  lo_pin_i,
  input logic [W-1:0]  hi_pin_i,
  input logic [W-1:0]  lo_oe_o,
  input logic [W-1:0]  lo_do_o,
  input logic [W-1:0]  hi_oe_o,
  input logic [W-1:0]  hi_do_o,
  input logic [W-1:0]  lo_latch_rd_o,
  input logic [W-1:0]  hi_latch_rd_o,
  input logic [W-1:0]  lo_pin_rd_o,
  input logic [W-1:0]  hi_pin_rd_o
);
  AST_LO_OPEN_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i == 2'b00 |-> (lo_oe_o == ~lo_latch_rd_o) && (lo_do_o == '0)); // R3
  AST_HI_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i == 2'b00 |-> (hi_oe_o == '1) && (hi_do_o == hi_latch_rd_o)); // R4
  AST_LO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i == 2'b01 |-> (lo_oe_o == '1) && (lo_do_o == bus_addr_i[W-1:0])); // R5
  AST_LO_DOUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i == 2'b10 |-> (lo_oe_o == '1) && (lo_do_o == bus_wdata_i)); // R6
  AST_LO_DIN_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i == 2'b11 |-> lo_oe_o == '0); // R7
  AST_LO_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i != 2'b00 |=> lo_latch_rd_o == '1); // R8
  AST_HI_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i != 2'b00 |-> (hi_oe_o == '1) && (hi_do_o == bus_addr_i[AW-1:W])); // R9
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_phase_i != 2'b00 |=> $stable(hi_latch_rd_o)); // R10
  AST_LO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_phase_i == 2'b00) && wr_lo_i |=> lo_latch_rd_o == $past(wdata_i)); // R2
  AST_PIN_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (lo_pin_rd_o == $past(lo_pin_i)) && (hi_pin_rd_o == $past(hi_pin_i))); // R11
endmodule

bind adp_port_pair adp_port_pair_chk #(.W(W)) u_chk (.*);

// File: tb/tb_adp_port_pair.sv
`timescale 1ns/100ps
module tb_adp_port_pair;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_lo = 0, wr_hi = 0;
  logic [W-1:0] wdata = '0, bwdata = '0, lo_pin = '0, hi_pin = '0;
  logic [1:0] phase = 2'b00;
  logic [2*W-1:0] baddr = '0;
  logic [W-1:0] lo_oe, lo_do, hi_oe, hi_do, lo_lr, hi_lr, lo_pr, hi_pr;

  int n_tests = 0, n_fail = 0;
  logic [W-1:0] m_lo, m_hi, m_lop, m_hip;

  always #2.5 clk = ~clk;

  adp_port_pair dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_lo_i(wr_lo), .wr_hi_i(wr_hi), .wdata_i(wdata),
    .bus_phase_i(phase), .bus_addr_i(baddr), .bus_wdata_i(bwdata),
    .lo_pin_i(lo_pin), .hi_pin_i(hi_pin),
    .lo_oe_o(lo_oe), .lo_do_o(lo_do), .hi_oe_o(hi_oe), .hi_do_o(hi_do),
    .lo_latch_rd_o(lo_lr), .hi_latch_rd_o(hi_lr), .lo_pin_rd_o(lo_pr), .hi_pin_rd_o(hi_pr)
  );

  task automatic chk(input string req, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_lo_oe(input logic [1:0] ph, input logic [W-1:0] l);
    case (ph)
      2'b00: return ~l;
      2'b11: return '0;
      default: return '1;
    endcase
  endfunction

  function automatic logic [W-1:0] exp_lo_do(input logic [1:0] ph, input logic [2*W-1:0] a, input logic [W-1:0] d);
    case (ph)
      2'b01: return a[W-1:0];
      2'b10: return d;
      default: return '0;
    endcase
  endfunction

  function automatic string lo_req(input logic [1:0] ph);
    case (ph)
      2'b00: return "R3";
      2'b01: return "R5";
      2'b10: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Check all outputs against the model, then advance one edge.
  task automatic step();
    #1;
    chk(lo_req(phase), "lo_oe", lo_oe, exp_lo_oe(phase, m_lo));
    chk(lo_req(phase), "lo_do", lo_do, exp_lo_do(phase, baddr, bwdata));
    if (phase == 2'b00) begin
      chk("R4", "hi_oe", hi_oe, '1);
      chk("R10", "hi_do", hi_do, m_hi);
    end else begin
      chk("R9", "hi_oe", hi_oe, '1);
      chk("R9", "hi_do", hi_do, baddr[2*W-1:W]);
    end
    chk("R8", "lo_latch", lo_lr, m_lo);
    chk("R10", "hi_latch", hi_lr, m_hi);
    chk("R11", "lo_pin_rd", lo_pr, m_lop);
    chk("R11", "hi_pin_rd", hi_pr, m_hip);
    @(posedge clk);
    if (phase != 2'b00) m_lo = '1;
    else if (wr_lo) m_lo = wdata;
    if (phase == 2'b00 && wr_hi) m_hi = wdata;
    m_lop = lo_pin;
    m_hip = hi_pin;
    @(negedge clk);
  endtask

  task automatic drive(input logic [1:0] ph, input logic wl, input logic wh, input logic [W-1:0] d);
    phase = ph; wr_lo = wl; wr_hi = wh; wdata = d;
    baddr = 16'($urandom); bwdata = 8'($urandom);
    lo_pin = 8'($urandom); hi_pin = 8'($urandom);
  endtask

  initial begin
    #200000;
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'hADD5_0C0E));
    m_lo = '1; m_hi = '1; m_lop = '0; m_hip = '0;
    lo_pin = 8'h5A; hi_pin = 8'hC3;
    #12;
    chk("R1", "lo_latch reset", lo_lr, 8'hFF);
    chk("R1", "hi_latch reset", hi_lr, 8'hFF);
    chk("R1", "lo_pin_rd reset", lo_pr, 8'h00);
    chk("R1", "hi_pin_rd reset", hi_pr, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    // R2: idle writes to both latches
    drive(2'b00, 1, 1, 8'h3C); step();
    drive(2'b00, 0, 0, 8'h00); step();
    chk("R2", "lo write", lo_lr, 8'h3C);
    chk("R2", "hi write", hi_lr, 8'h3C);
    drive(2'b00, 0, 1, 8'hA5); step();
    // full bus read cycle; R8 collision: lo write during address phase
    drive(2'b01, 1, 1, 8'h00); step();
    drive(2'b11, 1, 1, 8'h11); step();
    drive(2'b00, 0, 0, 8'h00); step();
    chk("R8", "lo forced after bus", lo_lr, 8'hFF);
    chk("R10", "hi held after bus", hi_lr, 8'hA5);
    chk("R10", "hi pins revert", hi_do, 8'hA5);
    // bus write cycle
    drive(2'b00, 1, 0, 8'h00); step();
    drive(2'b01, 0, 0, 8'h00); step();
    drive(2'b10, 0, 0, 8'h00); step();
    drive(2'b00, 0, 0, 8'h00); step();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] ph;
      ph = ($urandom_range(0, 1) == 0) ? 2'b00 : 2'($urandom);
      drive(ph, 1'($urandom), 1'($urandom), 8'($urandom));
      step();
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule